// File: doc/BRIEF.md
# Multiplexed Bus Memory Front End

This block sits between a byte-wide memory array and a microcontroller bus that shares its low address byte and its data on one set of pins. While the address-latch strobe is high, the low byte from the shared pins and the upper bits from dedicated pins pass through to the latched address. When the strobe drops, the address is frozen, and the shared pins carry data from then on.

All bus controls are asynchronous to the system clock. They enter through a synchronizer chain, and the bus pins travel through an alignment pipeline of the same depth, so address and data samples stay matched with the strobes that qualify them. A low program-fetch strobe or a low data-read strobe asks for array data to be driven back on the shared pins. Both strobes address the same array. The rising edge of the write strobe produces a one-cycle write pulse that carries the frozen address and the last bus byte seen while the write strobe was low. When the select input is inactive, the block reports standby and never drives the pins.

Top module: `mbus_mem_front`

## Requirements
- R1: Directly after reset, standby_o is 1, and ad_oe_o, rd_req_o and wr_stb_o are 0.
- R2: While the latch strobe ale_i is high, addr_o equals {hi_i, ad_i}, with hi_i in the upper 7 bits, and follows those pins SYNC_STAGES+1 clock cycles later.
- R3: After ale_i falls, addr_o holds its value however ad_i and hi_i change, until ale_i rises again.
- R4: A program fetch is select active, ale_i low, psen_n_i low, rd_n_i high and wr_n_i high. During a fetch, ad_oe_o and rd_req_o are 1 and ad_o equals the array byte rdata_i for the latched address.
- R5: A data read (psen_n_i high, rd_n_i low, wr_n_i high, select active, ale_i low) drives the array byte in the same way as R4.
- R6: When psen_n_i and rd_n_i are both low, or when a read strobe and wr_n_i are both low, ad_oe_o stays 0.
- R7: A rising edge of wr_n_i, taken with select active, ale_i low and both read strobes high, gives wr_stb_o for one cycle. In that cycle wr_data_o is the last ad_i byte sampled while wr_n_i was low, and addr_o is the latched address.
- R8: With select inactive (sel_i high under the default SEL_ACTIVE_LOW=1), standby_o is 1, ad_oe_o is 0, and a write strobe edge produces no wr_stb_o.
- R9: While ale_i is high, ad_oe_o is 0 even if a read strobe is low.
- R10: Each write strobe edge yields exactly one wr_stb_o pulse, never a pulse two cycles long.
- R11: Once the read strobe is released, ad_oe_o returns to 0 within SYNC_STAGES+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Address latch strobe, high = transparent |
| sel_i | input | 1 | Chip select, polarity set by SEL_ACTIVE_LOW |
| psen_n_i | input | 1 | Program-fetch read strobe, active low |
| rd_n_i | input | 1 | Data read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| ad_i | input | DW | Shared address/data pins, input side |
| hi_i | input | HI_W | Upper address pins |
| rdata_i | input | DW | Byte read from the array at addr_o |
| ad_o | output | DW | Shared pins, output side |
| ad_oe_o | output | 1 | Drive enable for ad_o; 0 = high impedance |
| addr_o | output | DW+HI_W | Latched array address |
| rd_req_o | output | 1 | Read access in progress |
| wr_stb_o | output | 1 | One-cycle array write pulse |
| wr_data_o | output | DW | Byte to write with wr_stb_o |
| standby_o | output | 1 | Select inactive |

## Verification
Reads are tried through the program-fetch strobe and through the data-read strobe at random addresses, on array contents that earlier writes have partly overwritten. This separates a read path that uses the latched address from one that uses live pins. During every data phase the bench puts junk on the address pins right after the latch strobe falls, which exposes a latch that stays transparent. Writes release the strobe and change the bus in the same cycle, which separates capture of the last byte sampled while the strobe was low from capture of a later byte. Directed cases cover both read strobes low, read with write, a read strobe during the latch phase, and a write edge while deselected. These show whether the drive enable and the write pulse are qualified by every condition.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

   // synchronized control strobes, after select polarity has been normalized
   typedef struct packed {
      logic ale;     // latch strobe, high = transparent
      logic sel;     // select, 1 = active
      logic psen_n;  // fetch strobe
      logic rd_n;    // data read strobe
      logic wr_n;    // write strobe
   } strb_t;

   localparam int STRB_W = $bits(strb_t);

   typedef enum logic [2:0] {
      MD_STANDBY,
      MD_LATCH,
      MD_IDLE,
      MD_FETCH,
      MD_DREAD,
      MD_CONFLICT
   } mode_e;

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 1) begin : g_bad_depth
      $error("mbus_sync: STAGES must be at least 1");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d_i;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
   parameter int DW   = 8,
   parameter int HI_W = 7,
   localparam int AW  = DW + HI_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ale_s,
   input  logic [DW-1:0] lo_s,
   input  logic [HI_W-1:0] hi_s,
   output logic [AW-1:0] addr_o
);

   logic [AW-1:0] addr_q;

   // transparent while the aligned strobe is high, frozen once it is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     addr_q <= '0;
      else if (ale_s) addr_q <= {hi_s, lo_s};
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/mbus_mode_decode.sv
module mbus_mode_decode
   import mbus_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  strb_t         s_i,
   input  logic [DW-1:0] lo_s,
   output logic          rd_q_o,
   output logic          wr_stb_o,
   output logic [DW-1:0] wr_data_o,
   output logic          standby_o
);

   mode_e         mode;
   logic          wr_prev;
   logic [DW-1:0] lo_prev;
   logic          wr_edge;
   logic          rd_q, wr_stb_q, standby_q;
   logic [DW-1:0] wr_data_q;

   always_comb begin
      if (!s_i.sel)                         mode = MD_STANDBY;
      else if (s_i.ale)                     mode = MD_LATCH;
      else if (!s_i.psen_n && !s_i.rd_n)    mode = MD_CONFLICT;
      else if (!s_i.wr_n && (!s_i.psen_n || !s_i.rd_n)) mode = MD_CONFLICT;
      else if (!s_i.psen_n)                 mode = MD_FETCH;
      else if (!s_i.rd_n)                   mode = MD_DREAD;
      else                                  mode = MD_IDLE;
   end

   // write edge: strobe high now, low in previous aligned sample, no read active
   assign wr_edge = (mode == MD_IDLE) && s_i.wr_n && !wr_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev   <= 1'b1;
         lo_prev   <= '0;
         rd_q      <= 1'b0;
         wr_stb_q  <= 1'b0;
         wr_data_q <= '0;
         standby_q <= 1'b1;
      end else begin
         wr_prev   <= s_i.wr_n;
         lo_prev   <= lo_s;
         standby_q <= (mode == MD_STANDBY);
         rd_q      <= (mode == MD_FETCH) || (mode == MD_DREAD);
         wr_stb_q  <= wr_edge;
         if (wr_edge) wr_data_q <= lo_prev;
      end
   end

   assign rd_q_o    = rd_q;
   assign wr_stb_o  = wr_stb_q;
   assign wr_data_o = wr_data_q;
   assign standby_o = standby_q;

endmodule

// File: rtl/mbus_mem_front.sv
module mbus_mem_front
   import mbus_pkg::*;
#(
   parameter int DW             = 8,
   parameter int HI_W           = 7,
   parameter int SYNC_STAGES    = 2,
   parameter bit SEL_ACTIVE_LOW = 1'b1,
   localparam int AW            = DW + HI_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ale_i,
   input  logic            sel_i,
   input  logic            psen_n_i,
   input  logic            rd_n_i,
   input  logic            wr_n_i,
   input  logic [DW-1:0]   ad_i,
   input  logic [HI_W-1:0] hi_i,
   input  logic [DW-1:0]   rdata_i,
   output logic [DW-1:0]   ad_o,
   output logic            ad_oe_o,
   output logic [AW-1:0]   addr_o,
   output logic            rd_req_o,
   output logic            wr_stb_o,
   output logic [DW-1:0]   wr_data_o,
   output logic            standby_o
);

   if (DW < 1)          begin : g_bad_dw   $error("mbus_mem_front: DW must be positive");        end
   if (HI_W < 0)        begin : g_bad_hi   $error("mbus_mem_front: HI_W must not be negative");  end
   if (SYNC_STAGES < 2) begin : g_bad_sync $error("mbus_mem_front: SYNC_STAGES must be >= 2");   end

   localparam strb_t STRB_RST = '{ale: 1'b0, sel: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};

   logic  sel_act;
   strb_t strb_raw, strb_s;
   logic [AW-1:0] bus_s;
   logic          ale_s;

   // select polarity variant
   if (SEL_ACTIVE_LOW) begin : g_sel_low
      assign sel_act = ~sel_i;
   end else begin : g_sel_high
      assign sel_act = sel_i;
   end

   assign strb_raw = '{ale: ale_i, sel: sel_act, psen_n: psen_n_i, rd_n: rd_n_i, wr_n: wr_n_i};

   mbus_sync #(.W(STRB_W), .STAGES(SYNC_STAGES), .RST_VAL(STRB_RST)) u_strb_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (strb_raw),
      .q_o   (strb_s)
   );

   // bus pins delayed by the same depth so samples line up with their strobes
   mbus_sync #(.W(AW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_align (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({hi_i, ad_i}),
      .q_o   (bus_s)
   );

   assign ale_s = strb_s.ale;

   mbus_addr_latch #(.DW(DW), .HI_W(HI_W)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ale_s  (ale_s),
      .lo_s   (bus_s[DW-1:0]),
      .hi_s   (bus_s[AW-1:DW]),
      .addr_o (addr_o)
   );

   mbus_mode_decode #(.DW(DW)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_i       (strb_s),
      .lo_s      (bus_s[DW-1:0]),
      .rd_q_o    (rd_req_o),
      .wr_stb_o  (wr_stb_o),
      .wr_data_o (wr_data_o),
      .standby_o (standby_o)
   );

   assign ad_oe_o = rd_req_o;
   assign ad_o    = rdata_i;

endmodule

// File: rtl/mbus_mem_front_chk.sv
module mbus_mem_front_chk #(
   parameter int AW = 15
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ale_s,
   input logic          ad_oe_o,
   input logic          standby_o,
   input logic          wr_stb_o,
   input logic [AW-1:0] addr_o
);

   AST_ADDR_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) !ale_s |=> $stable(addr_o));   // R3
   AST_WR_NO_DRIVE:    assert property (@(posedge clk) disable iff (!rst_n) wr_stb_o |-> !ad_oe_o);        // R7
   AST_OE_NEEDS_SEL:   assert property (@(posedge clk) disable iff (!rst_n) ad_oe_o |-> !standby_o);       // R8
   AST_STBY_NO_WRITE:  assert property (@(posedge clk) disable iff (!rst_n) standby_o |-> !wr_stb_o);      // R8
   AST_LATCH_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) ale_s |=> !ad_oe_o);           // R9
   AST_WR_ONE_CYCLE:   assert property (@(posedge clk) disable iff (!rst_n) wr_stb_o |=> !wr_stb_o);       // R10

endmodule

bind mbus_mem_front mbus_mem_front_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ale_s     (ale_s),
   .ad_oe_o   (ad_oe_o),
   .standby_o (standby_o),
   .wr_stb_o  (wr_stb_o),
   .addr_o    (addr_o)
);

// File: tb/mbus_mem_front_tb.sv
module mbus_mem_front_tb;

   localparam int DW = 8, HI_W = 7, AW = 15, MW = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ale = 1'b0, sel = 1'b1, psen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [DW-1:0] ad = '0, rdata;
   logic [HI_W-1:0] hi = '0;
   logic [DW-1:0] ad_o, wr_data;
   logic ad_oe, rd_req, wr_stb, standby;
   logic [AW-1:0] addr;

   int checks = 0, errors = 0, wr_cnt = 0;
   logic [AW-1:0] last_wa;
   logic [DW-1:0] last_wd;
   logic [DW-1:0] arr [1<<MW];
   logic [DW-1:0] mdl [1<<MW];
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   mbus_mem_front u_dut (
      .clk(clk), .rst_n(rst_n), .ale_i(ale), .sel_i(sel), .psen_n_i(psen_n),
      .rd_n_i(rd_n), .wr_n_i(wr_n), .ad_i(ad), .hi_i(hi), .rdata_i(rdata),
      .ad_o(ad_o), .ad_oe_o(ad_oe), .addr_o(addr), .rd_req_o(rd_req),
      .wr_stb_o(wr_stb), .wr_data_o(wr_data), .standby_o(standby)
   );

   // array model: synchronous read, written by the block's strobe
   always @(posedge clk) begin
      rdata <= arr[addr[MW-1:0]];
      if (wr_stb) begin
         arr[addr[MW-1:0]] <= wr_data;
         wr_cnt  <= wr_cnt + 1;
         last_wa <= addr;
         last_wd <= wr_data;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [DW-1:0] init_val(input int i);
      return DW'(i * 37 + 5);
   endfunction

   task automatic addr_phase(input logic [AW-1:0] a);
      ale = 1'b1; ad = a[DW-1:0]; hi = a[AW-1:DW];
      cyc(4);
      chk(addr == a, "R2", "transparent addr", addr, a);
      ale = 1'b0;
      ad = DW'($urandom); hi = HI_W'($urandom);
      cyc(4);
      chk(addr == a, "R3", "held addr", addr, a);
   endtask

   task automatic do_read(input logic [AW-1:0] a, input bit fetch);
      addr_phase(a);
      if (fetch) psen_n = 1'b0; else rd_n = 1'b0;
      cyc(6);
      chk(ad_oe && rd_req, fetch ? "R4" : "R5", "oe", ad_oe, 1);
      chk(ad_o == mdl[a[MW-1:0]], fetch ? "R4" : "R5", "data", ad_o, mdl[a[MW-1:0]]);
      psen_n = 1'b1; rd_n = 1'b1;
      cyc(3);
      chk(!ad_oe, "R11", "oe release", ad_oe, 0);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      int base;
      addr_phase(a);
      base = wr_cnt;
      wr_n = 1'b0; ad = d;
      cyc(4);
      wr_n = 1'b1; ad = ~d;          // bus changes together with the edge
      cyc(6);
      chk(wr_cnt == base + 1, "R10", "pulse count", wr_cnt - base, 1);
      chk(last_wa == a, "R7", "write addr", last_wa, a);
      chk(last_wd == d, "R7", "write data", last_wd, d);
      mdl[a[MW-1:0]] = d;
   endtask

   initial begin
      logic [AW-1:0] a;
      int base;
      void'($urandom(32'd2718));
      for (int i = 0; i < (1<<MW); i++) begin arr[i] = init_val(i); mdl[i] = init_val(i); end
      cyc(3);
      chk(standby && !ad_oe && !rd_req && !wr_stb, "R1", "reset outputs", {standby, ad_oe, rd_req, wr_stb}, 4'b1000);
      rst_n = 1'b1;
      cyc(2);
      sel = 1'b0;
      cyc(4);
      chk(!standby, "R8", "selected standby", standby, 0);

      do_read(15'h5a3c, 1'b1);
      do_read(15'h0123, 1'b0);
      do_write(15'h2aaa, 8'h55);
      do_read(15'h2aaa, 1'b0);
      do_write(15'h7fff, 8'h00);
      do_read(15'h7fff, 1'b1);

      // R6: both read strobes low
      addr_phase(15'h0040);
      psen_n = 1'b0; rd_n = 1'b0;
      cyc(6);
      chk(!ad_oe, "R6", "fetch+read oe", ad_oe, 0);
      psen_n = 1'b1;
      // R6: read with write low
      wr_n = 1'b0;
      cyc(6);
      chk(!ad_oe, "R6", "read+write oe", ad_oe, 0);
      // R8: deselect then release strobes: no write
      base = wr_cnt;
      sel = 1'b1;
      cyc(4);
      rd_n = 1'b1; wr_n = 1'b1;
      cyc(6);
      chk(wr_cnt == base, "R8", "write while deselected", wr_cnt - base, 0);
      chk(standby && !ad_oe, "R8", "standby/oe", {standby, ad_oe}, 2'b10);
      rd_n = 1'b0;
      cyc(6);
      chk(!ad_oe, "R8", "read while deselected", ad_oe, 0);
      rd_n = 1'b1;
      sel = 1'b0;
      cyc(4);

      // R9: read strobe during latch phase
      ale = 1'b1; ad = 8'h11; hi = 7'h22; psen_n = 1'b0;
      cyc(6);
      chk(!ad_oe, "R9", "oe during latch", ad_oe, 0);
      psen_n = 1'b1; ale = 1'b0;
      cyc(4);

      for (int k = 0; k < 40; k++) begin
         a = AW'($urandom);
         case ($urandom % 3)
            0: do_read(a, 1'b1);
            1: do_read(a, 1'b0);
            default: do_write(a, DW'($urandom));
         endcase
      end

      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule